// File: doc/BRIEF.md
# Counting Register Scoreboard

This block controls instruction issue in an in-order pipeline. Every architectural register in both the integer and the floating-point file has its own slot. Each slot holds a small counter of in-flight instructions that will still write that register, and a projected cycle at which the latest of those results is expected.

On the issue side, a candidate instruction presents up to two source registers, one destination register and the latency of the unit it targets. The block answers with a combinational can-issue verdict. A request that is accepted raises the destination count and records the ready cycle, which is the free-running cycle count plus the latency.

Two release ports lower counts. One is for normal commit. The other is for commit on a memory response. A flush returns every count to zero. Saturation and underflow leave the count clamped and raise a sticky error flag.

Top module: `counting_scoreboard`

## Requirements
- R1: `can_issue_o` is 1 exactly when every source whose valid bit is set refers to a register whose count is 0. A source whose valid bit is clear has no effect on the verdict.
- R2: When `issue_req_i` and `can_issue_o` are both 1 and the destination is valid, the destination count rises by one after the clock edge. When `can_issue_o` is 0, a request changes no count.
- R3: An accepted issue sets the destination's ready cycle to (`time_o` at the issuing edge + `lat_i`) modulo 2^TIME_W. A later issue to the same register overwrites it. Both are visible on `qry_ready_o`.
- R4: A valid entry on the commit port lowers that register's count by one.
- R5: A valid entry on the memory-response commit port lowers that register's count by one. When both release ports name the same register in one cycle, the count drops by two.
- R6: An accepted issue and a release of the same register in the same cycle leave its count unchanged.
- R7: Register files are selected by the `*_fp_i` bit (0 = integer, 1 = floating point). The same index in the two files refers to independent slots.
- R8: A count at its maximum (2^CNT_W-1, which is 7 by default) stays there on a further increment and sets `err_o`. `err_o` stays set until a flush.
- R9: A release of a register whose count is 0 leaves the count at 0 and sets `err_o`.
- R10: `flush_i` clears every count and `err_o` at the next edge. It takes priority over issue and release in the same cycle.
- R11: After reset, every count is 0, `err_o` is 0 and `time_o` is 0.
- R12: `time_o` advances by one on every clock edge after reset, wrapping modulo 2^TIME_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clear all counts and the error flag |
| src0_vld_i | input | 1 | Source 0 present |
| src0_fp_i | input | 1 | Source 0 file select (1 = floating point) |
| src0_idx_i | input | IDX_W | Source 0 register index |
| src1_vld_i | input | 1 | Source 1 present |
| src1_fp_i | input | 1 | Source 1 file select |
| src1_idx_i | input | IDX_W | Source 1 register index |
| dst_vld_i | input | 1 | Destination present |
| dst_fp_i | input | 1 | Destination file select |
| dst_idx_i | input | IDX_W | Destination register index |
| lat_i | input | LAT_W | Latency of the target unit in cycles |
| issue_req_i | input | 1 | Issue attempt this cycle |
| can_issue_o | output | 1 | All valid sources are free |
| cmt_vld_i | input | 1 | Commit release valid |
| cmt_fp_i | input | 1 | Commit release file select |
| cmt_idx_i | input | IDX_W | Commit release register index |
| mcmt_vld_i | input | 1 | Memory-response release valid |
| mcmt_fp_i | input | 1 | Memory-response release file select |
| mcmt_idx_i | input | IDX_W | Memory-response release register index |
| qry_fp_i | input | 1 | Query file select |
| qry_idx_i | input | IDX_W | Query register index |
| qry_cnt_o | output | CNT_W | Count of the queried register |
| qry_ready_o | output | TIME_W | Projected ready cycle of the queried register |
| time_o | output | TIME_W | Free-running cycle count |
| err_o | output | 1 | Sticky overflow or underflow flag |

## Verification
The count properties assume that a release only names a register with at least one pending writer. The only exception is the case the bench deliberately provokes for R9, where the properties check only that the count stays at zero. The hold property for refused issues also assumes that no release is active in the same cycle. The bench therefore drives each issue, release or flush on its own cycle, except in the scenarios that are about same-cycle interaction (R5, R6, R10). Every stimulus is applied on the falling edge so that it stays stable around the capturing edge.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_NUM_INT = 32;
  localparam int unsigned SB_NUM_FP  = 32;
  localparam int unsigned SB_CNT_W   = 3;
  localparam int unsigned SB_TIME_W  = 8;
  localparam int unsigned SB_LAT_W   = 4;

  function automatic int unsigned sb_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sb_timebase.sv
module sb_timebase #(
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_q + TIME_W'(1);
  end

  assign time_o = time_q;

  // R12
  time_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> time_o == $past(time_o) + TIME_W'(1));
endmodule

// File: rtl/sb_dec.sv
module sb_dec #(
  parameter int unsigned NUM_INT   = 32,
  parameter int unsigned NUM_FP    = 32,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned NUM_SLOTS = NUM_INT + NUM_FP
) (
  input  logic                 vld_i,
  input  logic                 fp_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_SLOTS-1:0] hot_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam bit          IS_FP = (g >= NUM_INT);
    localparam int unsigned LOC   = IS_FP ? (g - NUM_INT) : g;
    assign hot_o[g] = vld_i && (fp_i == IS_FP) && (idx_i == IDX_W'(LOC));
  end
endmodule

// File: rtl/sb_slot.sv
module sb_slot #(
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              inc_i,
  input  logic              dec_a_i,
  input  logic              dec_b_i,
  input  logic [TIME_W-1:0] ready_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [TIME_W-1:0] ready_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam logic [CNT_W:0]   CNT_LIM  = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MAXV = '1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TIME_W-1:0] ready_q;
  logic [CNT_W:0]    sum, dec, diff;
  logic              ovf, unf;

  always_comb begin
    sum  = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
    dec  = (CNT_W+1)'(dec_a_i) + (CNT_W+1)'(dec_b_i);
    diff = sum - dec;
    ovf  = 1'b0;
    unf  = 1'b0;
    if (sum < dec) begin
      unf   = 1'b1;
      cnt_d = '0;
    end else if (diff > CNT_LIM) begin
      ovf   = 1'b1;
      cnt_d = CNT_MAXV;
    end else begin
      cnt_d = diff[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= '0;
    end else if (flush_i) begin
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (inc_i) ready_q <= ready_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign ready_o = ready_q;
  assign ovf_o   = ovf && !flush_i;
  assign unf_o   = unf && !flush_i;

  // R2
  slot_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !dec_a_i && !dec_b_i && !flush_i && cnt_q != CNT_MAXV
    |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R6
  slot_balance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && (dec_a_i ^ dec_b_i) && !flush_i |=> cnt_q == $past(cnt_q));
  // R8
  slot_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !dec_a_i && !dec_b_i && !flush_i && cnt_q == CNT_MAXV |=> cnt_q == CNT_MAXV);
  // R9
  slot_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && (dec_a_i || dec_b_i) && !flush_i && cnt_q == '0 |=> cnt_q == '0);
  // R10
  slot_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0);
endmodule

// File: rtl/counting_scoreboard.sv
module counting_scoreboard
  import sb_pkg::*;
#(
  parameter int unsigned NUM_INT = SB_NUM_INT,
  parameter int unsigned NUM_FP  = SB_NUM_FP,
  parameter int unsigned CNT_W   = SB_CNT_W,
  parameter int unsigned TIME_W  = SB_TIME_W,
  parameter int unsigned LAT_W   = SB_LAT_W,
  parameter int unsigned IDX_W   = $clog2(sb_max(NUM_INT, NUM_FP))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              src0_vld_i,
  input  logic              src0_fp_i,
  input  logic [IDX_W-1:0]  src0_idx_i,
  input  logic              src1_vld_i,
  input  logic              src1_fp_i,
  input  logic [IDX_W-1:0]  src1_idx_i,
  input  logic              dst_vld_i,
  input  logic              dst_fp_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              issue_req_i,
  output logic              can_issue_o,
  input  logic              cmt_vld_i,
  input  logic              cmt_fp_i,
  input  logic [IDX_W-1:0]  cmt_idx_i,
  input  logic              mcmt_vld_i,
  input  logic              mcmt_fp_i,
  input  logic [IDX_W-1:0]  mcmt_idx_i,
  input  logic              qry_fp_i,
  input  logic [IDX_W-1:0]  qry_idx_i,
  output logic [CNT_W-1:0]  qry_cnt_o,
  output logic [TIME_W-1:0] qry_ready_o,
  output logic [TIME_W-1:0] time_o,
  output logic              err_o
);
  localparam int unsigned NUM_SLOTS = NUM_INT + NUM_FP;

  logic [NUM_SLOTS-1:0]       src0_hot, src1_hot, dst_hot, cmt_hot, mcmt_hot, qry_hot;
  logic [NUM_SLOTS-1:0]       busy, inc, ovf, unf;
  logic [CNT_W-1:0]           cnt_w   [NUM_SLOTS];
  logic [TIME_W-1:0]          ready_w [NUM_SLOTS];
  logic [NUM_SLOTS*CNT_W-1:0] cnt_flat;
  logic [TIME_W-1:0]          now, ready_in;
  logic                       fire, err_q;

  sb_timebase #(.TIME_W(TIME_W)) i_timebase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .time_o(now)
  );

  sb_dec #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W)) i_dec_src0 (
    .vld_i(src0_vld_i), .fp_i(src0_fp_i), .idx_i(src0_idx_i), .hot_o(src0_hot));
  sb_dec #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W)) i_dec_src1 (
    .vld_i(src1_vld_i), .fp_i(src1_fp_i), .idx_i(src1_idx_i), .hot_o(src1_hot));
  sb_dec #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W)) i_dec_dst (
    .vld_i(dst_vld_i), .fp_i(dst_fp_i), .idx_i(dst_idx_i), .hot_o(dst_hot));
  sb_dec #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W)) i_dec_cmt (
    .vld_i(cmt_vld_i), .fp_i(cmt_fp_i), .idx_i(cmt_idx_i), .hot_o(cmt_hot));
  sb_dec #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W)) i_dec_mcmt (
    .vld_i(mcmt_vld_i), .fp_i(mcmt_fp_i), .idx_i(mcmt_idx_i), .hot_o(mcmt_hot));
  sb_dec #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W)) i_dec_qry (
    .vld_i(1'b1), .fp_i(qry_fp_i), .idx_i(qry_idx_i), .hot_o(qry_hot));

  // sources are judged on registered counts only; same-cycle release does not unblock
  assign can_issue_o = !(|(src0_hot & busy)) && !(|(src1_hot & busy));
  assign fire        = issue_req_i && can_issue_o;
  assign inc         = dst_hot & {NUM_SLOTS{fire}};
  assign ready_in    = now + TIME_W'(lat_i);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    sb_slot #(.CNT_W(CNT_W), .TIME_W(TIME_W)) i_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flush_i(flush_i),
      .inc_i  (inc[g]),
      .dec_a_i(cmt_hot[g]),
      .dec_b_i(mcmt_hot[g]),
      .ready_i(ready_in),
      .cnt_o  (cnt_w[g]),
      .ready_o(ready_w[g]),
      .ovf_o  (ovf[g]),
      .unf_o  (unf[g])
    );
    assign busy[g] = |cnt_w[g];
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_w[g];
  end

  always_comb begin
    qry_cnt_o   = '0;
    qry_ready_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (qry_hot[s]) begin
        qry_cnt_o   = qry_cnt_o | cnt_w[s];
        qry_ready_o = qry_ready_o | ready_w[s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_q <= 1'b0;
    else if (flush_i)           err_q <= 1'b0;
    else if (|(ovf | unf))      err_q <= 1'b1;
  end

  assign err_o  = err_q;
  assign time_o = now;

  // R2
  no_fire_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !can_issue_o && !cmt_vld_i && !mcmt_vld_i && !flush_i |=> $stable(cnt_flat));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !flush_i |=> err_o);
endmodule

// File: tb/test_counting_scoreboard.sv
`timescale 1ns/100ps
module test_counting_scoreboard;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flush_i;
  logic       src0_vld_i, src0_fp_i, src1_vld_i, src1_fp_i;
  logic [4:0] src0_idx_i, src1_idx_i;
  logic       dst_vld_i, dst_fp_i;
  logic [4:0] dst_idx_i;
  logic [3:0] lat_i;
  logic       issue_req_i, can_issue_o;
  logic       cmt_vld_i, cmt_fp_i, mcmt_vld_i, mcmt_fp_i;
  logic [4:0] cmt_idx_i, mcmt_idx_i;
  logic       qry_fp_i;
  logic [4:0] qry_idx_i;
  logic [2:0] qry_cnt_o;
  logic [7:0] qry_ready_o, time_o;
  logic       err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  counting_scoreboard i_counting_scoreboard (
    .clk_i, .rst_ni, .flush_i,
    .src0_vld_i, .src0_fp_i, .src0_idx_i,
    .src1_vld_i, .src1_fp_i, .src1_idx_i,
    .dst_vld_i, .dst_fp_i, .dst_idx_i, .lat_i,
    .issue_req_i, .can_issue_o,
    .cmt_vld_i, .cmt_fp_i, .cmt_idx_i,
    .mcmt_vld_i, .mcmt_fp_i, .mcmt_idx_i,
    .qry_fp_i, .qry_idx_i, .qry_cnt_o, .qry_ready_o,
    .time_o, .err_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    flush_i = 0; issue_req_i = 0; lat_i = 0;
    src0_vld_i = 0; src0_fp_i = 0; src0_idx_i = 0;
    src1_vld_i = 0; src1_fp_i = 0; src1_idx_i = 0;
    dst_vld_i = 0; dst_fp_i = 0; dst_idx_i = 0;
    cmt_vld_i = 0; cmt_fp_i = 0; cmt_idx_i = 0;
    mcmt_vld_i = 0; mcmt_fp_i = 0; mcmt_idx_i = 0;
  endtask

  task automatic rd(input bit fp, input int idx, output int cnt, output int rdy);
    @(negedge clk_i);
    qry_fp_i = fp; qry_idx_i = idx[4:0];
    #1;
    cnt = qry_cnt_o; rdy = qry_ready_o;
  endtask

  task automatic chk_cnt(input string tag, input bit fp, input int idx, input int exp);
    int c, r;
    rd(fp, idx, c, r);
    chk(tag, c, exp);
  endtask

  // one accepted issue, returns time_o at the issuing edge
  task automatic do_issue(input bit fp, input int idx, input int lat, output int t);
    @(negedge clk_i);
    dst_vld_i = 1; dst_fp_i = fp; dst_idx_i = idx[4:0]; lat_i = lat[3:0]; issue_req_i = 1;
    t = time_o;
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_cmt(input bit fp, input int idx, input bit mem);
    @(negedge clk_i);
    if (mem) begin mcmt_vld_i = 1; mcmt_fp_i = fp; mcmt_idx_i = idx[4:0]; end
    else     begin cmt_vld_i = 1;  cmt_fp_i = fp;  cmt_idx_i = idx[4:0];  end
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_flush();
    @(negedge clk_i); flush_i = 1;
    @(negedge clk_i); idle();
  endtask

  task automatic t_reset();
    int t0;
    chk("R11 count after reset int0", 0, 0);
    chk_cnt("R11 count after reset int0", 0, 0, 0);
    chk_cnt("R11 count after reset fp31", 1, 31, 0);
    chk("R11 err after reset", err_o, 0);
    @(negedge clk_i); t0 = time_o;
    @(negedge clk_i); chk("R12 time step", time_o, (t0 + 1) % 256);
  endtask

  task automatic t_issue();
    int t, c, r;
    do_issue(0, 5, 3, t);
    rd(0, 5, c, r);
    chk("R2 count after issue int5", c, 1);
    chk("R3 ready int5", r, (t + 3) % 256);
    @(negedge clk_i);
    src0_vld_i = 1; src0_fp_i = 0; src0_idx_i = 5;
    dst_vld_i = 1; dst_idx_i = 6; issue_req_i = 1;
    #1 chk("R1 busy source blocks", can_issue_o, 0);
    @(negedge clk_i); idle();
    chk_cnt("R2 refused issue leaves int6", 0, 6, 0);
    @(negedge clk_i);
    src0_vld_i = 0; src0_idx_i = 5; src1_vld_i = 1; src1_fp_i = 1; src1_idx_i = 5;
    #1 chk("R1 invalid busy source ignored", can_issue_o, 1);
    idle();
  endtask

  task automatic t_files();
    int t;
    chk_cnt("R7 fp5 independent of int5", 1, 5, 0);
    do_issue(1, 5, 1, t);
    chk_cnt("R7 fp5 after fp issue", 1, 5, 1);
    chk_cnt("R7 int5 unchanged", 0, 5, 1);
  endtask

  task automatic t_release();
    int t;
    do_cmt(0, 5, 0);
    chk_cnt("R4 commit int5", 0, 5, 0);
    do_cmt(1, 5, 1);
    chk_cnt("R5 mem commit fp5", 1, 5, 0);
    do_issue(0, 7, 1, t);
    do_issue(0, 7, 1, t);
    chk_cnt("R2 two issues int7", 0, 7, 2);
    @(negedge clk_i);
    cmt_vld_i = 1; cmt_idx_i = 7; mcmt_vld_i = 1; mcmt_idx_i = 7;
    @(negedge clk_i); idle();
    chk_cnt("R5 dual release int7", 0, 7, 0);
    chk("R5 no err", err_o, 0);
  endtask

  task automatic t_same();
    int t;
    do_issue(0, 8, 2, t);
    @(negedge clk_i);
    dst_vld_i = 1; dst_idx_i = 8; issue_req_i = 1; cmt_vld_i = 1; cmt_idx_i = 8;
    @(negedge clk_i); idle();
    chk_cnt("R6 issue+commit int8", 0, 8, 1);
  endtask

  task automatic t_ready();
    int t, c, r;
    do_issue(0, 12, 15, t);
    rd(0, 12, c, r);
    chk("R3 ready lat15", r, (t + 15) % 256);
    do_issue(0, 12, 2, t);
    rd(0, 12, c, r);
    chk("R3 ready overwrite", r, (t + 2) % 256);
    chk("R2 int12 count", c, 2);
  endtask

  task automatic t_sat();
    int t;
    for (int i = 0; i < 7; i++) do_issue(0, 9, 1, t);
    chk_cnt("R8 int9 at max", 0, 9, 7);
    chk("R8 no err at max", err_o, 0);
    do_issue(0, 9, 1, t);
    chk_cnt("R8 int9 saturated", 0, 9, 7);
    chk("R8 err on overflow", err_o, 1);
    do_cmt(0, 9, 0);
    chk_cnt("R8 int9 after commit", 0, 9, 6);
    chk("R8 err sticky", err_o, 1);
  endtask

  task automatic t_flush();
    @(negedge clk_i);
    flush_i = 1; dst_vld_i = 1; dst_idx_i = 10; issue_req_i = 1;
    @(negedge clk_i); idle();
    chk_cnt("R10 int9 cleared", 0, 9, 0);
    chk_cnt("R10 int8 cleared", 0, 8, 0);
    chk_cnt("R10 issue under flush dropped", 0, 10, 0);
    chk("R10 err cleared", err_o, 0);
  endtask

  task automatic t_underflow();
    do_cmt(0, 11, 1);
    chk_cnt("R9 int11 stays zero", 0, 11, 0);
    chk("R9 err on underflow", err_o, 1);
    do_flush();
    chk("R10 err cleared again", err_o, 0);
  endtask

  initial begin
    idle();
    qry_fp_i = 0; qry_idx_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1 chk("R11 time after reset", time_o, 0);
    t_reset();
    t_issue();
    t_files();
    t_release();
    t_same();
    t_ready();
    t_sat();
    t_flush();
    t_underflow();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule